// File: doc/BRIEF.md
# Dual Word FIFO with Self-Clearing Flush and Trigger Requests

This block holds the data words that move between a host register interface and the serial engine of a controller. It has two queues of 32-bit words. The transmit queue is filled by host writes and drained by the engine. The receive queue is filled by the engine and drained by host reads. Every word carries four payload bytes. The earliest byte travels in bits 7:0, and in a short final word only the low byte lanes are meaningful. The block passes words through unchanged, so this byte packing is kept end to end.

The host sees four word registers. Their byte offsets are as follows:
- 0x0: control register.
- 0x4: packed status register.
- 0x8: transmit data. A write pushes one word.
- 0xC: receive data. A read pops one word.

Bits 1:0 of the address must be zero, and any address bits above bit 3 must also be zero; otherwise the access hits nothing. The control register holds a 3-bit trigger level for each queue and one flush bit for each queue. A flush bit stays set while its flush is in progress and clears itself when the flush completes.

Two request levels tell the host when to act. One asks for more transmit data. The other reports that receive data is waiting. Two single-cycle error pulses flag a write into a full transmit queue and a read from an empty receive queue.

Both engine-side paths use valid/ready with the usual rules. A word moves on the clock edge where valid and ready are both high. On the transmit side, the block keeps `eng_tx_valid` high and `eng_tx_data` steady until the engine accepts the word; a flush is the only exception. On the receive side, the engine must hold `eng_rx_valid` and `eng_rx_data` until `eng_rx_ready` goes high. `eng_rx_ready` is low while the receive queue is full or being flushed.

Top module: `fifo_word_pair`

## Requirements
- R1: After reset both queues are empty. The status register reads 0x80, the control register reads 0x00, the transmit request is high, the receive request is low, `eng_tx_valid` is low and `eng_rx_ready` is high.
- R2: Words written to offset 0x8 reach the engine in write order with all 32 bits unchanged. The first payload byte stays in bits 7:0.
- R3: Words that the engine pushes are returned by reads of offset 0xC in push order with all bits unchanged.
- R4: Status bits 7:4 give the number of free transmit slots (0 to 8). Status bits 3:0 give the number of words in the receive queue. The register reflects every accepted transfer on the cycle after the edge that took it.
- R5: A write to offset 0x8 while the transmit queue holds 8 words is discarded and leaves the queue contents unchanged. `tx_overflow` is high for exactly the one cycle after that write.
- R6: A read of offset 0xC while the receive queue is empty returns zero and leaves the queue unchanged. `rx_underflow` is high for exactly the one cycle after that read.
- R7: Writing 1 to control bit 1 flushes the transmit queue, and writing 1 to control bit 0 flushes the receive queue. The bit reads back as 1 for one cycle. After that it reads 0 and the queue is empty. The other queue is untouched.
- R8: In the cycle a flush is in progress, that queue accepts no push and no pop. Host writes to 0x8 are dropped without an overflow pulse, `eng_tx_valid` is low for a transmit flush, and `eng_rx_ready` is low for a receive flush.
- R9: The transmit trigger level is control bits 7:5 and the receive trigger level is control bits 4:2. Both read back as written, and both are 0 after reset.
- R10: `tx_req` is high exactly when the number of free transmit slots is greater than the transmit trigger level.
- R11: `rx_req` is high exactly when the receive fill is greater than the receive trigger level. With a trigger of 0, one stored word is enough.
- R12: `eng_tx_valid` is low when the transmit queue is empty. While `eng_tx_ready` is low, the offered word is held steady. `eng_rx_ready` is low while the receive queue holds 8 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (pops on offset 0xC) |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, combinational from the address |
| eng_tx_valid | output | 1 | Transmit word offered to the engine |
| eng_tx_ready | input | 1 | Engine accepts the offered transmit word |
| eng_tx_data | output | DATA_W | Transmit word at the head of the queue |
| eng_rx_valid | input | 1 | Engine offers a received word |
| eng_rx_ready | output | 1 | Receive queue can take a word |
| eng_rx_data | input | DATA_W | Received word from the engine |
| tx_req | output | 1 | Transmit queue wants more data |
| rx_req | output | 1 | Receive queue has data above the trigger level |
| tx_overflow | output | 1 | One-cycle pulse after a write into a full transmit queue |
| rx_underflow | output | 1 | One-cycle pulse after a read from an empty receive queue |

## Verification
The bound checker watches, on every cycle, the rules that hold between cycles:
- a flush empties its queue and lasts one cycle;
- no handshake completes during a flush;
- error pulses follow only a full or empty state, and an overflowing write leaves the count alone;
- counts move by at most one per cycle;
- the offered transmit word holds under back-pressure.

Only the bench scenarios can show the rest:
- that data arrives in order with its byte lanes intact;
- that the status nibbles match a reference queue model under mixed traffic;
- that trigger thresholds switch the requests at the exact fill levels;
- that underflowing reads return zero.

// File: rtl/wfp_pkg.sv
`timescale 1ns/1ps
package wfp_pkg;
  // register select taken from address bits 3:2
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_TXD  = 2'd2,
    SEL_RXD  = 2'd3
  } reg_sel_e;

  localparam int unsigned TRIG_W = 3;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned CTRL_W = 2 * TRIG_W + 2;

  // control layout, MSB first: tx trigger 7:5, rx trigger 4:2, tx flush 1, rx flush 0
  typedef struct packed {
    logic [TRIG_W-1:0] tx_trig;
    logic [TRIG_W-1:0] rx_trig;
    logic              tx_flush;
    logic              rx_flush;
  } ctrl_t;
endpackage

// File: rtl/wfp_fifo.sv
`timescale 1ns/1ps
module wfp_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [DW-1:0]    push_data_i,
  input  logic             pop_i,
  output logic [DW-1:0]    head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic             do_push, do_pop;

  assign full_o  = (count_o == CNT_W'(DEPTH));
  assign empty_o = (count_o == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign head_o  = mem[rd_ptr];

  generate
    if (DEPTH == (1 << PTR_W)) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else if (flush_i) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_nxt;
      if (do_pop)  rd_ptr <= rd_nxt;
      case ({do_push, do_pop})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data_i;
  end
endmodule

// File: rtl/wfp_ctrl.sv
`timescale 1ns/1ps
module wfp_ctrl
  import wfp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_i,
  input  ctrl_t wdata_i,
  output ctrl_t cfg_o
);
  // a flush bit lives for exactly one cycle: set by the write, cleared by the next edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_o <= '0;
    end else begin
      cfg_o.tx_flush <= wr_i && wdata_i.tx_flush;
      cfg_o.rx_flush <= wr_i && wdata_i.rx_flush;
      if (wr_i) begin
        cfg_o.tx_trig <= wdata_i.tx_trig;
        cfg_o.rx_trig <= wdata_i.rx_trig;
      end
    end
  end
endmodule

// File: rtl/wfp_status.sv
`timescale 1ns/1ps
module wfp_status
  import wfp_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0]    tx_cnt_i,
  input  logic [CNT_W-1:0]    rx_cnt_i,
  input  logic [TRIG_W-1:0]   tx_trig_i,
  input  logic [TRIG_W-1:0]   rx_trig_i,
  output logic [2*NIB_W-1:0]  stat_o,
  output logic                tx_req_o,
  output logic                rx_req_o
);
  logic [CNT_W-1:0] tx_free;

  assign tx_free  = CNT_W'(DEPTH) - tx_cnt_i;
  assign stat_o   = {NIB_W'(tx_free), NIB_W'(rx_cnt_i)};
  assign tx_req_o = 32'(tx_free)  > 32'(tx_trig_i);
  assign rx_req_o = 32'(rx_cnt_i) > 32'(rx_trig_i);
endmodule

// File: rtl/fifo_word_pair.sv
`timescale 1ns/1ps
module fifo_word_pair
  import wfp_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              eng_tx_valid,
  input  logic              eng_tx_ready,
  output logic [DATA_W-1:0] eng_tx_data,
  input  logic              eng_rx_valid,
  output logic              eng_rx_ready,
  input  logic [DATA_W-1:0] eng_rx_data,
  output logic              tx_req,
  output logic              rx_req,
  output logic              tx_overflow,
  output logic              rx_underflow
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic              hi_zero, addr_ok;
  reg_sel_e          sel;
  logic              wr_ctrl, wr_txd, rd_rxd;
  ctrl_t             cfg_q;
  logic              tx_flush, rx_flush;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [DATA_W-1:0] rx_head;
  logic [2*NIB_W-1:0] stat;
  logic              tx_pop, rx_push;

  generate
    if (ADDR_W > 4) begin : g_hi
      assign hi_zero = (host_addr[ADDR_W-1:4] == '0);
    end else begin : g_nohi
      assign hi_zero = 1'b1;
    end
  endgenerate

  assign addr_ok = hi_zero && (host_addr[1:0] == 2'b00);
  assign sel     = reg_sel_e'(host_addr[3:2]);
  assign wr_ctrl = host_wr && addr_ok && (sel == SEL_CTRL);
  assign wr_txd  = host_wr && addr_ok && (sel == SEL_TXD);
  assign rd_rxd  = host_rd && addr_ok && (sel == SEL_RXD);

  wfp_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_ctrl),
    .wdata_i (ctrl_t'(host_wdata[CTRL_W-1:0])),
    .cfg_o   (cfg_q)
  );

  assign tx_flush = cfg_q.tx_flush;
  assign rx_flush = cfg_q.rx_flush;

  // engine handshakes
  assign eng_tx_valid = !tx_empty && !tx_flush;
  assign tx_pop       = eng_tx_valid && eng_tx_ready;
  assign eng_rx_ready = !rx_full && !rx_flush;
  assign rx_push      = eng_rx_valid && eng_rx_ready;

  wfp_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (tx_flush),
    .push_i      (wr_txd),
    .push_data_i (host_wdata),
    .pop_i       (tx_pop),
    .head_o      (eng_tx_data),
    .count_o     (tx_cnt),
    .full_o      (tx_full),
    .empty_o     (tx_empty)
  );

  wfp_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (rx_flush),
    .push_i      (rx_push),
    .push_data_i (eng_rx_data),
    .pop_i       (rd_rxd),
    .head_o      (rx_head),
    .count_o     (rx_cnt),
    .full_o      (rx_full),
    .empty_o     (rx_empty)
  );

  wfp_status #(.DEPTH(DEPTH)) u_stat (
    .tx_cnt_i  (tx_cnt),
    .rx_cnt_i  (rx_cnt),
    .tx_trig_i (cfg_q.tx_trig),
    .rx_trig_i (cfg_q.rx_trig),
    .stat_o    (stat),
    .tx_req_o  (tx_req),
    .rx_req_o  (rx_req)
  );

  // error pulses, one cycle after the offending access
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_overflow  <= 1'b0;
      rx_underflow <= 1'b0;
    end else begin
      tx_overflow  <= wr_txd && tx_full && !tx_flush;
      rx_underflow <= rd_rxd && rx_empty && !rx_flush;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (addr_ok) begin
      case (sel)
        SEL_CTRL: host_rdata = DATA_W'(cfg_q);
        SEL_STAT: host_rdata = DATA_W'(stat);
        SEL_RXD:  host_rdata = (rx_empty || rx_flush) ? '0 : rx_head;
        default:  host_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/wfp_checker.sv
`timescale 1ns/1ps
module wfp_checker #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic [3:0]        host_addr_lo,
  input logic              wdata_txf,
  input logic              eng_tx_valid,
  input logic              eng_tx_ready,
  input logic [DATA_W-1:0] eng_tx_data,
  input logic              eng_rx_ready,
  input logic              tx_req,
  input logic              rx_req,
  input logic              tx_overflow,
  input logic              rx_underflow,
  input logic [CNT_W-1:0]  tx_cnt,
  input logic [CNT_W-1:0]  rx_cnt,
  input logic              tx_flush,
  input logic              rx_flush
);
  logic txd_wr, txf_wr;
  assign txd_wr = host_wr && (host_addr_lo == 4'h8);
  assign txf_wr = host_wr && (host_addr_lo == 4'h0) && wdata_txf;

  a_r7_tx_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> (tx_cnt == '0));
  a_r7_rx_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> (rx_cnt == '0));
  a_r7_flush_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flush && !txf_wr) |=> !tx_flush);
  a_r8_tx_quiet_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |-> !eng_tx_valid);
  a_r8_rx_quiet_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |-> !eng_rx_ready);
  a_r5_ovf_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    tx_overflow |-> ($past(tx_cnt) == CNT_W'(DEPTH)));
  a_r5_ovf_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_wr && tx_cnt == CNT_W'(DEPTH) && !tx_flush && !(eng_tx_valid && eng_tx_ready))
      |=> (tx_cnt == CNT_W'(DEPTH)));
  a_r6_unf_only_empty: assert property (@(posedge clk) disable iff (!rst_n)
    rx_underflow |-> ($past(rx_cnt) == '0));
  a_r10_no_tx_req_full: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == CNT_W'(DEPTH)) |-> !tx_req);
  a_r11_rx_req_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req |-> (rx_cnt != '0));
  a_r12_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_tx_valid && !eng_tx_ready) |=> (tx_flush || (eng_tx_valid && $stable(eng_tx_data))));
  a_r12_rx_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == CNT_W'(DEPTH)) |-> !eng_rx_ready);
  a_r4_tx_step: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_flush |=> ((tx_cnt == $past(tx_cnt)) || (tx_cnt == $past(tx_cnt) + 1'b1)
                   || (tx_cnt + 1'b1 == $past(tx_cnt))));
endmodule

bind fifo_word_pair wfp_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_wr      (host_wr),
  .host_addr_lo (host_addr[3:0]),
  .wdata_txf    (host_wdata[1]),
  .eng_tx_valid (eng_tx_valid),
  .eng_tx_ready (eng_tx_ready),
  .eng_tx_data  (eng_tx_data),
  .eng_rx_ready (eng_rx_ready),
  .tx_req       (tx_req),
  .rx_req       (rx_req),
  .tx_overflow  (tx_overflow),
  .rx_underflow (rx_underflow),
  .tx_cnt       (tx_cnt),
  .rx_cnt       (rx_cnt),
  .tx_flush     (tx_flush),
  .rx_flush     (rx_flush)
);

// File: tb/sim_fifo_word_pair.sv
`timescale 1ns/1ps
module sim_fifo_word_pair;
  localparam int CLK_NS = 8;
  localparam logic [3:0] A_CTRL = 4'h0, A_STAT = 4'h4, A_TXD = 4'h8, A_RXD = 4'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic        eng_tx_valid, eng_tx_ready = 1'b0;
  logic [31:0] eng_tx_data;
  logic        eng_rx_valid = 1'b0, eng_rx_ready;
  logic [31:0] eng_rx_data = '0;
  logic        tx_req, rx_req, tx_overflow, rx_underflow;

  int n_chk = 0, n_bad = 0;
  logic [31:0] txq[$];
  logic [31:0] rxq[$];

  always #(CLK_NS/2) clk = ~clk;

  fifo_word_pair u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready), .eng_tx_data(eng_tx_data),
    .eng_rx_valid(eng_rx_valid), .eng_rx_ready(eng_rx_ready), .eng_rx_data(eng_rx_data),
    .tx_req(tx_req), .rx_req(rx_req), .tx_overflow(tx_overflow), .rx_underflow(rx_underflow)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic host_write(logic [3:0] a, logic [31:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(logic [3:0] a, output logic [31:0] d);
    host_rd = 1'b1; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic chk_stat(string req, int free, int cnt);
    logic [31:0] v;
    host_read(A_STAT, v);
    chk(req, v, 32'((free << 4) | cnt));
  endtask

  task automatic eng_pop(string req, logic [31:0] exp);
    eng_tx_ready = 1'b1;
    #1 chk(req, {31'b0, eng_tx_valid}, 32'd1);
    chk(req, eng_tx_data, exp);
    @(negedge clk);
    eng_tx_ready = 1'b0;
  endtask

  task automatic eng_push(string req, logic [31:0] d);
    eng_rx_valid = 1'b1; eng_rx_data = d;
    #1 chk(req, {31'b0, eng_rx_ready}, 32'd1);
    @(negedge clk);
    eng_rx_valid = 1'b0;
  endtask

  task automatic clean();
    host_write(A_CTRL, 32'h3);
    tick();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk_stat("R1", 8, 0);
    host_read(A_CTRL, v);
    chk("R1", v, 32'h0);
    chk("R1", {31'b0, tx_req}, 1);
    chk("R1", {31'b0, rx_req}, 0);
    chk("R1", {31'b0, eng_tx_valid}, 0);
    chk("R1", {31'b0, eng_rx_ready}, 1);
  endtask

  task automatic t_tx_order();
    host_write(A_TXD, 32'h44332211);
    host_write(A_TXD, 32'h88776655);
    host_write(A_TXD, 32'h000000CC);
    chk_stat("R4", 5, 0);
    // back-pressure: word held while ready low (R12)
    for (int i = 0; i < 3; i++) begin
      #1 chk("R12", {31'b0, eng_tx_valid}, 1);
      chk("R12", eng_tx_data, 32'h44332211);
      tick();
    end
    eng_pop("R2", 32'h44332211);
    chk("R2", {24'b0, eng_tx_data[7:0]}, 32'h55);
    eng_pop("R2", 32'h88776655);
    eng_pop("R2", 32'h000000CC);
    #1 chk("R12", {31'b0, eng_tx_valid}, 0);
    chk_stat("R4", 8, 0);
  endtask

  task automatic t_rx_order();
    logic [31:0] v;
    eng_push("R3", 32'hA1B2C3D4);
    eng_push("R3", 32'h0BADF00D);
    eng_push("R3", 32'h12345678);
    chk_stat("R4", 8, 3);
    host_read(A_RXD, v); chk("R3", v, 32'hA1B2C3D4);
    host_read(A_RXD, v); chk("R3", v, 32'h0BADF00D);
    host_read(A_RXD, v); chk("R3", v, 32'h12345678);
    chk_stat("R4", 8, 0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 8; i++) host_write(A_TXD, 32'h100 + 32'(i));
    chk_stat("R4", 0, 0);
    chk("R10", {31'b0, tx_req}, 0);
    host_write(A_TXD, 32'hDEADBEEF);
    chk("R5", {31'b0, tx_overflow}, 1);
    tick();
    chk("R5", {31'b0, tx_overflow}, 0);
    chk_stat("R5", 0, 0);
    for (int i = 0; i < 8; i++) eng_pop("R5", 32'h100 + 32'(i));
    #1 chk("R5", {31'b0, eng_tx_valid}, 0);
    tick();
  endtask

  task automatic t_underflow();
    logic [31:0] v;
    host_read(A_RXD, v);
    chk("R6", v, 32'h0);
    chk("R6", {31'b0, rx_underflow}, 1);
    tick();
    chk("R6", {31'b0, rx_underflow}, 0);
    chk_stat("R6", 8, 0);
    for (int i = 0; i < 8; i++) eng_push("R12", 32'h200 + 32'(i));
    #1 chk("R12", {31'b0, eng_rx_ready}, 0);
    tick();
    clean();
    chk_stat("R7", 8, 0);
  endtask

  task automatic t_flush();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) host_write(A_TXD, 32'h300 + 32'(i));
    for (int i = 0; i < 3; i++) eng_push("R3", 32'h400 + 32'(i));
    host_write(A_CTRL, 32'h2);
    eng_tx_ready = 1'b1;
    #1 chk("R8", {31'b0, eng_tx_valid}, 0);
    eng_tx_ready = 1'b0;
    host_read(A_CTRL, v);
    chk("R7", v, 32'h2);
    host_read(A_CTRL, v);
    chk("R7", v, 32'h0);
    chk_stat("R7", 8, 3);
    host_write(A_CTRL, 32'h1);
    eng_rx_valid = 1'b1; eng_rx_data = 32'h55AA55AA;
    #1 chk("R8", {31'b0, eng_rx_ready}, 0);
    tick();
    eng_rx_valid = 1'b0;
    chk_stat("R7", 8, 0);
    host_write(A_CTRL, 32'h2);
    host_write(A_TXD, 32'hCAFE0001);
    chk("R8", {31'b0, tx_overflow}, 0);
    chk_stat("R8", 8, 0);
  endtask

  task automatic t_triggers();
    logic [31:0] v;
    host_write(A_CTRL, 32'hA8);
    host_read(A_CTRL, v);
    chk("R9", v, 32'hA8);
    chk("R10", {31'b0, tx_req}, 1);
    host_write(A_TXD, 32'h1);
    host_write(A_TXD, 32'h2);
    chk("R10", {31'b0, tx_req}, 1);
    host_write(A_TXD, 32'h3);
    chk("R10", {31'b0, tx_req}, 0);
    eng_push("R11", 32'h9);
    eng_push("R11", 32'hA);
    chk("R11", {31'b0, rx_req}, 0);
    eng_push("R11", 32'hB);
    chk("R11", {31'b0, rx_req}, 1);
    clean();
    host_read(A_CTRL, v);
    chk("R9", v, 32'h0);
    eng_push("R11", 32'hC);
    chk("R11", {31'b0, rx_req}, 1);
    host_read(A_RXD, v);
    chk("R11", {31'b0, rx_req}, 0);
  endtask

  task automatic t_random();
    logic [31:0] v, w;
    logic ovf_exp;
    txq.delete(); rxq.delete();
    for (int i = 0; i < 300; i++) begin
      w = $urandom();
      case ($urandom_range(0, 5))
        0: begin
          ovf_exp = (txq.size() == 8);
          host_write(A_TXD, w);
          if (!ovf_exp) txq.push_back(w);
          chk("R5", {31'b0, tx_overflow}, {31'b0, ovf_exp});
        end
        1: if (txq.size() > 0) begin
          eng_pop("R2", txq[0]);
          void'(txq.pop_front());
        end else begin
          #1 chk("R12", {31'b0, eng_tx_valid}, 0);
          tick();
        end
        2: if (rxq.size() < 8) begin
          eng_push("R3", w);
          rxq.push_back(w);
        end else begin
          #1 chk("R12", {31'b0, eng_rx_ready}, 0);
          tick();
        end
        3: begin
          host_read(A_RXD, v);
          if (rxq.size() > 0) begin
            chk("R3", v, rxq[0]);
            void'(rxq.pop_front());
          end else begin
            chk("R6", v, 0);
          end
        end
        4: begin
          v = 32'($urandom_range(1, 3));
          host_write(A_CTRL, v);
          tick();
          if (v[1]) txq.delete();
          if (v[0]) rxq.delete();
        end
        default: tick();
      endcase
      chk_stat("R4", 8 - txq.size(), rxq.size());
      chk("R10", {31'b0, tx_req}, {31'b0, txq.size() < 8});
      chk("R11", {31'b0, rx_req}, {31'b0, rxq.size() > 0});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tx_order();
    t_rx_order();
    t_overflow();
    t_underflow();
    t_flush();
    clean();
    t_triggers();
    clean();
    t_random();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule